// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the byte-wide programming model of a 16550-class serial port. A host issues single-cycle reads and writes at eight register offsets. The block stores the configuration registers and returns read data combinationally in the same cycle. Read and write side effects take effect at the clock edge that ends the access. When the line-control register's latch-access bit is set, the lowest two offsets switch over to the two divisor bytes.

The block does no bit-level shifting and no baud timing. A receive FIFO outside the block reports whether it holds data, the byte at its head, and an overrun pulse. In return, the block pops that FIFO, flushes it, and tells it whether deep (FIFO) mode is on. A modem-status source supplies four line levels, which the block ignores in loopback mode. A data-register write shows up as a one-cycle transmit strobe carrying the byte.

The transmitter always looks idle. The write-data interrupt is a sticky flag: a data write sets it, and an identification read that reports it clears it. The level interrupt output is asserted while any enabled interrupt reason is pending.

Top module: `serial_reg_front`

## Requirements
- R1: After reset the divisor low byte is 12 and the high byte 0. The enable, line-control, modem-control and scratch registers read 0. The identification register reads 0x01 and `irq` is low.
- R2: While line-control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. A write to offset 0 in that state raises no transmit strobe.
- R3: A write to the enable register (offset 1) keeps only bits 3:0. A write to modem control (offset 4) keeps only bits 4:0.
- R4: Identification (offset 2 read) reports, by priority, one of the following codes in bits 3:0. Overrun gated by enable bit 2 gives 0x6. Receive data present gated by enable bit 0 gives 0xC. Write-data pending gated by enable bit 1 gives 0x2. Any modem delta gated by enable bit 3 gives 0x0. With nothing pending the code is 0x1.
- R5: A data write (offset 0, latch bit clear) sets write-data pending. An identification read that returns code 0x2 clears it.
- R6: Identification bits 7:6 read 11 while the stored FIFO-enable bit (bit 0 of the last FIFO-control write) is set, else 00.
- R7: Line status (offset 5) always shows bits 6 and 5 set. Bit 0 equals receive-data-present. Bit 1 is the overrun flag, which an `rxOverrun` pulse sets and a line-status read returns and then clears.
- R8: A FIFO-control write (offset 2) with bit 0 clear stores 0 there; otherwise it keeps bits 7:6, 3 and 0. `rxFlush` pulses when bit 0 changes, or when bits 0 and 1 are both written 1. `rxDeep` shows the stored enable.
- R9: Writes to line status and modem status have no effect on what those registers read.
- R10: Modem status (offset 6) shows the lines in bits 7:4 as {DCD, RI, DSR, CTS}. In loopback (modem-control bit 4) these come from modem-control bits {3, 2, 0, 1}; otherwise they come from `modemIn` {3..0}. Bits 0, 1 and 3 latch changes of CTS, DSR and DCD. Bit 2 latches a falling RI. A modem-status read clears bits 3:0.
- R11: A data read returns `rxHead` with a one-cycle `rxPop` when data is present. It returns 0xFF with no pop when the receive FIFO is empty. A data write pulses `txStrobe` with `txByte` equal to the written byte.
- R12: Scratch (offset 7) and line control (offset 3) read back the full byte last written.
- R13: `irq` is high exactly when the identification code would not be 0x1. It follows `rxNotEmpty` without waiting for an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Access valid this cycle |
| regWrite | input | 1 | 1 write, 0 read |
| regAddr | input | 3 | Register offset |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data (same cycle) |
| rxNotEmpty | input | 1 | Receive FIFO holds data |
| rxHead | input | 8 | Byte at receive FIFO head |
| rxOverrun | input | 1 | Receive FIFO dropped a byte |
| rxPop | output | 1 | Consume head byte |
| rxFlush | output | 1 | Empty the receive FIFO |
| rxDeep | output | 1 | Deep FIFO mode selected |
| modemIn | input | 4 | Modem lines {DCD,RI,DSR,CTS} |
| txStrobe | output | 1 | Transmit byte strobe |
| txByte | output | 8 | Transmit byte |
| loopMode | output | 1 | Loopback selected |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every combination of the four interrupt sources against all sixteen enable masks. A priority slip therefore shows up as a wrong code or a stuck `irq`. It also shows if the receive condition reports the plain data code instead of the timeout code, or if a reported write-data interrupt survives its own identification read. Loopback toggles check that RI sets its delta only on a falling edge and that deltas vanish after one status read. A design that cleared them early, or missed them, would return the wrong status byte. FIFO-control writes that keep, change or reset the enable expose a missing or spurious flush. Divisor aliasing is checked so that a latch-mode write to offset 0 cannot leak out as a transmit strobe.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_IIR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_LCR  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_MCR  = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_LSR  = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_MSR  = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_SCR  = 3'd7;

  typedef enum logic [3:0] {
    CAUSE_MODEM = 4'h0,
    CAUSE_NONE  = 4'h1,
    CAUSE_THRE  = 4'h2,
    CAUSE_LINE  = 4'h6,
    CAUSE_RXTO  = 4'hC
  } causeT;

  typedef struct packed {
    logic wrDivLo;
    logic wrDivHi;
    logic wrTx;
    logic wrIer;
    logic wrFcr;
    logic wrLcr;
    logic wrMcr;
    logic wrScr;
    logic rdRx;
    logic rdIir;
    logic rdLsr;
    logic rdMsr;
  } regStrobeT;
endpackage

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
(
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              dlab,
  output regStrobeT         stb
);
  logic wrAcc, rdAcc;

  always_comb begin
    wrAcc = regSel && regWrite;
    rdAcc = regSel && !regWrite;
    stb = '0;
    stb.wrDivLo = wrAcc && dlab && (regAddr == OFF_DATA);
    stb.wrDivHi = wrAcc && dlab && (regAddr == OFF_IER);
    stb.wrTx    = wrAcc && !dlab && (regAddr == OFF_DATA);
    stb.wrIer   = wrAcc && !dlab && (regAddr == OFF_IER);
    stb.wrFcr   = wrAcc && (regAddr == OFF_IIR);
    stb.wrLcr   = wrAcc && (regAddr == OFF_LCR);
    stb.wrMcr   = wrAcc && (regAddr == OFF_MCR);
    stb.wrScr   = wrAcc && (regAddr == OFF_SCR);
    stb.rdRx    = rdAcc && !dlab && (regAddr == OFF_DATA);
    stb.rdIir   = rdAcc && (regAddr == OFF_IIR);
    stb.rdLsr   = rdAcc && (regAddr == OFF_LSR);
    stb.rdMsr   = rdAcc && (regAddr == OFF_MSR);
  end
endmodule

// File: rtl/sreg_dp.sv
module sreg_dp
  import sreg_pkg::*;
#(
  parameter int REF_CLK_HZ = 1843200,
  parameter int DEF_BAUD   = 9600
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobeT         stb,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic              rxNotEmpty,
  input  logic [BYTE_W-1:0] rxHead,
  input  logic              rxOverrun,
  output logic              rxPop,
  output logic              rxFlush,
  output logic              rxDeep,
  input  logic [3:0]        modemIn,
  output logic              txStrobe,
  output logic [BYTE_W-1:0] txByte,
  output logic              loopMode,
  output logic              irq,
  output logic              dlab,
  output logic              oeQ,
  output logic              thrPendQ,
  output logic [3:0]        ierQ
);
  localparam int DIV_RAW = REF_CLK_HZ / DEF_BAUD / 16;
  localparam logic [15:0] DIV_RST = DIV_RAW[15:0];
  localparam logic [BYTE_W-1:0] FCR_KEEP = 8'hC9;

  logic [BYTE_W-1:0] divLoQ, divHiQ, lcrQ, scrQ, fcrQ;
  logic [4:0] mcrQ;
  logic [3:0] linesQ, linesNext, deltaQ, deltaNew;
  causeT cause;
  logic fifoOn, flushNow;

  assign dlab     = lcrQ[7];
  assign loopMode = mcrQ[4];
  assign fifoOn   = fcrQ[0];
  assign rxDeep   = fifoOn;
  assign txStrobe = stb.wrTx;
  assign txByte   = regWdata;
  assign rxPop    = stb.rdRx && rxNotEmpty;

  // modem line source and delta detection
  always_comb begin
    if (mcrQ[4]) linesNext = {mcrQ[3], mcrQ[2], mcrQ[0], mcrQ[1]};
    else         linesNext = modemIn;
    deltaNew[0] = linesNext[0] ^ linesQ[0];
    deltaNew[1] = linesNext[1] ^ linesQ[1];
    deltaNew[2] = linesQ[2] && !linesNext[2];
    deltaNew[3] = linesNext[3] ^ linesQ[3];
  end

  // prioritized interrupt cause
  always_comb begin
    if (oeQ && ierQ[2])             cause = CAUSE_LINE;
    else if (rxNotEmpty && ierQ[0]) cause = CAUSE_RXTO;
    else if (thrPendQ && ierQ[1])   cause = CAUSE_THRE;
    else if ((|deltaQ) && ierQ[3])  cause = CAUSE_MODEM;
    else                            cause = CAUSE_NONE;
  end
  assign irq = (cause != CAUSE_NONE);

  always_comb begin
    flushNow = 1'b0;
    if (stb.wrFcr)
      flushNow = (regWdata[0] ^ fcrQ[0]) || (regWdata[0] && regWdata[1]);
  end
  assign rxFlush = flushNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLoQ   <= DIV_RST[7:0];
      divHiQ   <= DIV_RST[15:8];
      lcrQ     <= '0;
      scrQ     <= '0;
      fcrQ     <= '0;
      mcrQ     <= '0;
      ierQ     <= '0;
      oeQ      <= 1'b0;
      thrPendQ <= 1'b0;
      linesQ   <= '0;
      deltaQ   <= '0;
    end else begin
      if (stb.wrDivLo) divLoQ <= regWdata;
      if (stb.wrDivHi) divHiQ <= regWdata;
      if (stb.wrLcr)   lcrQ   <= regWdata;
      if (stb.wrScr)   scrQ   <= regWdata;
      if (stb.wrIer)   ierQ   <= regWdata[3:0];
      if (stb.wrMcr)   mcrQ   <= regWdata[4:0];
      if (stb.wrFcr)   fcrQ   <= regWdata[0] ? (regWdata & FCR_KEEP) : '0;
      if (rxOverrun)       oeQ <= 1'b1;
      else if (stb.rdLsr)  oeQ <= 1'b0;
      if (stb.wrTx)
        thrPendQ <= 1'b1;
      else if (stb.rdIir && cause == CAUSE_THRE)
        thrPendQ <= 1'b0;
      linesQ <= linesNext;
      deltaQ <= (stb.rdMsr ? 4'b0 : deltaQ) | deltaNew;
    end
  end

  // read data mux
  always_comb begin
    regRdata = '0;
    if (regSel && !regWrite) begin
      case (regAddr)
        OFF_DATA: regRdata = dlab ? divLoQ : (rxNotEmpty ? rxHead : 8'hFF);
        OFF_IER:  regRdata = dlab ? divHiQ : {4'b0, ierQ};
        OFF_IIR:  regRdata = {fifoOn, fifoOn, 2'b00, cause};
        OFF_LCR:  regRdata = lcrQ;
        OFF_MCR:  regRdata = {3'b0, mcrQ};
        OFF_LSR:  regRdata = {1'b0, 2'b11, 3'b000, oeQ, rxNotEmpty};
        OFF_MSR:  regRdata = {linesQ, deltaQ};
        default:  regRdata = scrQ;
      endcase
    end
  end
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import sreg_pkg::*;
#(
  parameter int REF_CLK_HZ = 1843200,
  parameter int DEF_BAUD   = 9600
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        regWrite,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        rxNotEmpty,
  input  logic [7:0]  rxHead,
  input  logic        rxOverrun,
  output logic        rxPop,
  output logic        rxFlush,
  output logic        rxDeep,
  input  logic [3:0]  modemIn,
  output logic        txStrobe,
  output logic [7:0]  txByte,
  output logic        loopMode,
  output logic        irq
);
  regStrobeT stb;
  logic dlab, oeQ, thrPendQ;
  logic [3:0] ierQ;

  sreg_ctrl i_ctrl (
    .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr),
    .dlab(dlab), .stb(stb)
  );

  sreg_dp #(.REF_CLK_HZ(REF_CLK_HZ), .DEF_BAUD(DEF_BAUD)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .rxNotEmpty(rxNotEmpty), .rxHead(rxHead), .rxOverrun(rxOverrun),
    .rxPop(rxPop), .rxFlush(rxFlush), .rxDeep(rxDeep),
    .modemIn(modemIn), .txStrobe(txStrobe), .txByte(txByte),
    .loopMode(loopMode), .irq(irq),
    .dlab(dlab), .oeQ(oeQ), .thrPendQ(thrPendQ), .ierQ(ierQ)
  );
endmodule

// File: rtl/serial_reg_front_chk.sv
module serial_reg_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regSel,
  input logic       regWrite,
  input logic [2:0] regAddr,
  input logic [7:0] regRdata,
  input logic       rxNotEmpty,
  input logic       rxOverrun,
  input logic       rxPop,
  input logic       rxFlush,
  input logic       irq,
  input logic       dlab,
  input logic       oeQ,
  input logic       thrPendQ,
  input logic [3:0] ierQ
);
  AST_IER_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWrite && regAddr == 3'd1 && !dlab) |-> (regRdata[7:4] == 4'b0)); // R3
  AST_LSR_TX_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWrite && regAddr == 3'd5) |-> (regRdata[6:5] == 2'b11)); // R7
  AST_OE_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWrite && regAddr == 3'd5 && !rxOverrun) |=> !oeQ); // R7
  AST_THRE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWrite && regAddr == 3'd0 && !dlab) |=> thrPendQ); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (ierQ == 4'b0) |-> !irq); // R13
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> rxNotEmpty); // R11
  AST_FLUSH_ON_FCR: assert property (@(posedge clk) disable iff (!rstN)
    rxFlush |-> (regSel && regWrite && regAddr == 3'd2)); // R8
endmodule

bind serial_reg_front serial_reg_front_chk i_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
  .regAddr(regAddr), .regRdata(regRdata), .rxNotEmpty(rxNotEmpty),
  .rxOverrun(rxOverrun), .rxPop(rxPop), .rxFlush(rxFlush), .irq(irq),
  .dlab(dlab), .oeQ(oeQ), .thrPendQ(thrPendQ), .ierQ(ierQ)
);

// File: tb/test_serial_reg_front.sv
`timescale 1ns/1ps
module test_serial_reg_front;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, regWrite = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0, regRdata;
  logic rxNotEmpty = 1'b0, rxOverrun = 1'b0;
  logic [7:0] rxHead = '0;
  logic rxPop, rxFlush, rxDeep, txStrobe, loopMode, irq;
  logic [7:0] txByte;
  logic [3:0] modemIn = '0;

  int checks = 0;
  int errors = 0;
  logic lastTx, lastFlush, lastPop;
  logic [7:0] lastTxByte;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  serial_reg_front i_serial_reg_front (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .rxNotEmpty(rxNotEmpty), .rxHead(rxHead), .rxOverrun(rxOverrun),
    .rxPop(rxPop), .rxFlush(rxFlush), .rxDeep(rxDeep), .modemIn(modemIn),
    .txStrobe(txStrobe), .txByte(txByte), .loopMode(loopMode), .irq(irq)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    #1;
    lastTx = txStrobe; lastTxByte = txByte; lastFlush = rxFlush;
    @(posedge clk); #1;
    regSel = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b0; regAddr = a;
    #1;
    d = regRdata; lastPop = rxPop;
    @(posedge clk); #1;
    regSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] expIir(input logic [3:0] src, input logic [3:0] en);
    if (src[0] && en[2]) return 8'h06;
    if (src[1] && en[0]) return 8'h0C;
    if (src[2] && en[1]) return 8'h02;
    if (src[3] && en[3]) return 8'h00;
    return 8'h01;
  endfunction

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    summary;
    $finish;
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    chk(irq, 0, "R1 irq");
    rdReg(3'd2, rv); chk(rv, 8'h01, "R1 iir");
    rdReg(3'd1, rv); chk(rv, 8'h00, "R1 ier");
    rdReg(3'd3, rv); chk(rv, 8'h00, "R1 lcr");
    rdReg(3'd4, rv); chk(rv, 8'h00, "R1 mcr");
    rdReg(3'd7, rv); chk(rv, 8'h00, "R1 scr");
    wrReg(3'd3, 8'h80);
    rdReg(3'd0, rv); chk(rv, 12, "R1 divisor low");
    rdReg(3'd1, rv); chk(rv, 0, "R1 divisor high");
    // R2 aliasing
    wrReg(3'd0, 8'h34); chk(lastTx, 0, "R2 no tx in latch mode");
    wrReg(3'd1, 8'h56);
    rdReg(3'd0, rv); chk(rv, 8'h34, "R2 div low");
    rdReg(3'd1, rv); chk(rv, 8'h56, "R2 div high");
    wrReg(3'd3, 8'h03);
    rdReg(3'd1, rv); chk(rv, 8'h00, "R2 ier unaffected");
    // R12 line control and scratch
    rdReg(3'd3, rv); chk(rv, 8'h03, "R12 lcr");
    for (int v = 0; v < 256; v++) begin
      wrReg(3'd7, v[7:0]);
      rdReg(3'd7, rv); chk(rv, v, "R12 scratch");
    end
    // R3 masks
    wrReg(3'd1, 8'hF0);
    rdReg(3'd1, rv); chk(rv, 8'h00, "R3 ier upper");
    wrReg(3'd4, 8'hFF);
    rdReg(3'd4, rv); chk(rv, 8'h1F, "R3 mcr mask");
    chk(loopMode, 1, "R10 loop on");
    wrReg(3'd4, 8'h10);
    idle(2);
    rdReg(3'd6, rv); rdReg(3'd6, rv); chk(rv, 8'h00, "R10 msr settled");
    // R11 data path
    rxNotEmpty = 1'b1; rxHead = 8'hA5;
    rdReg(3'd0, rv); chk(rv, 8'hA5, "R11 head"); chk(lastPop, 1, "R11 pop");
    rxNotEmpty = 1'b0;
    rdReg(3'd0, rv); chk(rv, 8'hFF, "R11 empty"); chk(lastPop, 0, "R11 no pop");
    wrReg(3'd0, 8'h5A); chk(lastTx, 1, "R11 strobe"); chk(lastTxByte, 8'h5A, "R11 byte");
    // R7 line status
    rdReg(3'd5, rv); chk(rv, 8'h60, "R7 empty");
    rxNotEmpty = 1'b1;
    @(negedge clk); rxOverrun = 1'b1; @(posedge clk); #1; rxOverrun = 1'b0;
    rdReg(3'd5, rv); chk(rv, 8'h63, "R7 overrun");
    rdReg(3'd5, rv); chk(rv, 8'h61, "R7 overrun cleared");
    rxNotEmpty = 1'b0;
    // R9 writes ignored
    wrReg(3'd5, 8'hFF);
    rdReg(3'd5, rv); chk(rv, 8'h60, "R9 lsr");
    wrReg(3'd6, 8'hFF);
    rdReg(3'd6, rv); chk(rv, 8'h00, "R9 msr");
    // R10 loopback and deltas
    wrReg(3'd4, 8'h1F); idle(2);
    rdReg(3'd6, rv); chk(rv, 8'hFB, "R10 rise");
    rdReg(3'd6, rv); chk(rv, 8'hF0, "R10 clear");
    wrReg(3'd4, 8'h10); idle(2);
    rdReg(3'd6, rv); chk(rv, 8'h0F, "R10 fall with TERI");
    rdReg(3'd6, rv); chk(rv, 8'h00, "R10 clear2");
    modemIn = 4'hF; idle(2);
    rdReg(3'd6, rv); chk(rv, 8'h00, "R10 lines ignored in loop");
    modemIn = 4'h0;
    wrReg(3'd4, 8'h00); modemIn = 4'h1; idle(2);
    rdReg(3'd6, rv); chk(rv, 8'h11, "R10 external cts");
    modemIn = 4'h0; idle(2);
    rdReg(3'd6, rv);
    wrReg(3'd4, 8'h10); idle(2);
    rdReg(3'd6, rv); chk(rv, 8'h00, "R10 quiet");
    // R8 / R6 FIFO control
    wrReg(3'd2, 8'h01); chk(lastFlush, 1, "R8 flush on enable");
    chk(rxDeep, 1, "R8 deep");
    rdReg(3'd2, rv); chk(rv, 8'hC1, "R6 top bits");
    wrReg(3'd2, 8'hC9); chk(lastFlush, 0, "R8 no flush");
    wrReg(3'd2, 8'h03); chk(lastFlush, 1, "R8 flush on reset bit");
    wrReg(3'd2, 8'h02); chk(lastFlush, 1, "R8 flush on disable");
    chk(rxDeep, 0, "R8 stored zero");
    rdReg(3'd2, rv); chk(rv, 8'h01, "R6 off");
    // R4 / R5 / R13 priority sweep
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        wrReg(3'd1, 8'h00);
        rxNotEmpty = 1'b0;
        rdReg(3'd5, rv); rdReg(3'd6, rv);
        wrReg(3'd1, 8'h02); rdReg(3'd2, rv);
        wrReg(3'd1, 8'h00);
        if (s[3]) begin wrReg(3'd4, 8'h12); idle(1); wrReg(3'd4, 8'h10); idle(2); end
        if (s[2]) wrReg(3'd0, 8'h00);
        if (s[0]) begin @(negedge clk); rxOverrun = 1'b1; @(posedge clk); #1; rxOverrun = 1'b0; end
        if (s[1]) rxNotEmpty = 1'b1;
        wrReg(3'd1, {4'b0, e[3:0]});
        idle(1);
        chk(irq, expIir(s[3:0], e[3:0]) != 8'h01, "R13 irq level");
        rdReg(3'd2, rv); chk(rv, expIir(s[3:0], e[3:0]), "R4 iir code");
      end
    end
    // R5 sticky write flag cleared by its own report
    rxNotEmpty = 1'b0;
    rdReg(3'd5, rv); rdReg(3'd6, rv);
    wrReg(3'd1, 8'h02);
    wrReg(3'd0, 8'h11);
    rdReg(3'd2, rv); chk(rv, 8'h02, "R5 pending");
    rdReg(3'd2, rv); chk(rv, 8'h01, "R5 cleared");
    chk(irq, 0, "R5 irq low");
    summary;
    $finish;
  end
endmodule